// File: doc/BRIEF.md
# Prefix-Driven Register Selector

This unit sits beside the instruction decoder of a small 16-bit coprocessor. In that coprocessor, an ordinary instruction does not name its source and destination registers. Short prefix opcodes issued in front of it choose them, and the choice holds until the instruction completes.

The unit holds the sixteen general registers. It also keeps the prefix state:
- a bind flag,
- two alternate-meaning flags,
- the current source index,
- the current destination index.

The datapath reads the source register through `src_data` and writes results through the write port into the current destination. It pulses `clear_flags` when an ordinary instruction finishes, which returns the prefix state to its idle form.

One opcode group has two meanings, chosen by the bind flag that the previous prefix left behind. With the bind flag clear, it only redirects the destination. With the bind flag set, it copies the source register into the named register in one cycle, then clears the prefix state.

The unit also produces two strobes in the same cycle as the opcode:
- `pc_step`: tells the fetch logic whether to advance the program counter. It stays low when a copy lands in the register that holds the program counter.
- `rom_req`: asks for a ROM read when a copy lands in the ROM-address register.

Top module: `pfx_select_unit`

## Requirements
- R1: After reset, `b_flag`, `alt1` and `alt2` are 0, `src_sel` and `dst_sel` are 0, and every register holds 0, so `src_data` reads 0 for any source selected.
- R2: An accepted opcode 0x2n sets `b_flag` and makes register n both source and destination from the next cycle. `alt1` and `alt2` keep their values.
- R3: An accepted opcode 0x1n with `b_flag` clear sets `dst_sel` to n from the next cycle. `src_sel`, `b_flag`, `alt1` and `alt2` are left unchanged, and no register changes.
- R4: An accepted opcode 0x1n with `b_flag` set copies the current source register into register n. From the next cycle, `b_flag`, `alt1` and `alt2` are 0 and both selects are 0.
- R5: Accepted opcode 0x3D sets `alt1`, 0x3E sets `alt2` and 0x3F sets both. Each of them clears `b_flag`, leaves the other alternate flag and both selects unchanged, and never clears an alternate flag that is already set.
- R6: `clear_flags` high at a clock edge zeroes `b_flag`, `alt1`, `alt2`, `src_sel` and `dst_sel`. An opcode presented in the same cycle is ignored: no state change, no copy, and both strobes low.
- R7: `pc_step` is high, in the same cycle, for every accepted prefix opcode (0x10–0x2F, 0x3D–0x3F). The one exception is a copy into register 15, for which it is low. It is low for every other opcode.
- R8: `rom_req` is high, in the same cycle, only for an accepted copy into register 14 (opcode 0x1E with `b_flag` set).
- R9: `wr_en` writes `wr_data` into the register named by `dst_sel` at the clock edge, including in a cycle with `clear_flags`. When a copy happens in the same cycle, the copy is performed and the datapath write is dropped.
- R10: Opcodes outside 0x10–0x2F and 0x3D–0x3F leave every flag, select and register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 8 | Opcode byte |
| clear_flags | input | 1 | Datapath completion pulse that resets prefix state |
| wr_en | input | 1 | Datapath write into the destination register |
| wr_data | input | DATA_W | Datapath write value |
| b_flag | output | 1 | Bind flag |
| alt1 | output | 1 | First alternate-meaning flag |
| alt2 | output | 1 | Second alternate-meaning flag |
| src_sel | output | 4 | Current source register index |
| dst_sel | output | 4 | Current destination register index |
| src_data | output | DATA_W | Contents of the current source register |
| pc_step | output | 1 | Advance the program counter for this opcode |
| rom_req | output | 1 | ROM read request caused by a copy into register 14 |

## Verification
The hardest state to reach is a copy. It needs the bind flag to have been set by an earlier opcode, and the registers to hold distinct, known values so that a wrong source or target shows up. The bench first loads every register through the datapath write port, one bind opcode per register. It then sweeps every source and target pair with a bind opcode followed by a select opcode, and reads each result back through `src_data` by binding the target. A second sweep presents all 256 opcodes, once with the bind flag set and once with it clear, including the same-cycle collisions of a copy with a datapath write and of an opcode with `clear_flags`.

// File: rtl/pfx_select_pkg.sv
package pfx_select_pkg;

    localparam int IDX_W    = 4;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] PC_REG  = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] ROM_REG = IDX_W'(NUM_REGS - 2);

    localparam logic [3:0] GRP_SELDST = 4'h1;
    localparam logic [3:0] GRP_BIND   = 4'h2;
    localparam logic [7:0] OP_ALT1    = 8'h3D;
    localparam logic [7:0] OP_ALT2    = 8'h3E;
    localparam logic [7:0] OP_ALT12   = 8'h3F;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_SELDST,
        PK_BIND,
        PK_ALT1,
        PK_ALT2,
        PK_ALT12
    } pfx_kind_e;

    typedef struct packed {
        pfx_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } pfx_dec_t;

    typedef struct packed {
        logic b;
        logic a1;
        logic a2;
    } pfx_flags_t;

    typedef struct packed {
        pfx_flags_t       flags;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } pfx_state_t;

    localparam pfx_state_t PFX_IDLE = '{flags: '0, src: '0, dst: '0};

    function automatic pfx_dec_t classify(input logic [7:0] op);
        pfx_dec_t d;
        d.idx  = op[IDX_W-1:0];
        d.kind = PK_NONE;
        if (op[7:4] == GRP_SELDST)    d.kind = PK_SELDST;
        else if (op[7:4] == GRP_BIND) d.kind = PK_BIND;
        else if (op == OP_ALT1)       d.kind = PK_ALT1;
        else if (op == OP_ALT2)       d.kind = PK_ALT2;
        else if (op == OP_ALT12)      d.kind = PK_ALT12;
        return d;
    endfunction

endpackage

// File: rtl/pfx_decoder.sv
module pfx_decoder
    import pfx_select_pkg::*;
(
    input  logic             op_valid,
    input  logic [7:0]       opcode,
    input  logic             clear_flags,
    input  logic             bind_now,
    output pfx_dec_t         dec,
    output logic             do_copy,
    output logic [IDX_W-1:0] copy_idx,
    output logic             pc_step,
    output logic             rom_req
);

    logic accept;

    always_comb begin
        dec      = classify(opcode);
        accept   = op_valid && !clear_flags && (dec.kind != PK_NONE);
        do_copy  = accept && (dec.kind == PK_SELDST) && bind_now;
        copy_idx = dec.idx;
        pc_step  = accept && !(do_copy && (dec.idx == PC_REG));
        rom_req  = do_copy && (dec.idx == ROM_REG);
    end

endmodule

// File: rtl/pfx_state.sv
module pfx_state
    import pfx_select_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic       clear_flags,
    input  pfx_dec_t   dec,
    output pfx_state_t st
);

    pfx_state_t nxt;

    always_comb begin
        nxt = st;
        if (clear_flags) begin
            nxt = PFX_IDLE;
        end else if (op_valid) begin
            unique case (dec.kind)
                PK_SELDST: begin
                    if (st.flags.b) nxt = PFX_IDLE;
                    else            nxt.dst = dec.idx;
                end
                PK_BIND: begin
                    nxt.flags.b = 1'b1;
                    nxt.src     = dec.idx;
                    nxt.dst     = dec.idx;
                end
                PK_ALT1: begin
                    nxt.flags.a1 = 1'b1;
                    nxt.flags.b  = 1'b0;
                end
                PK_ALT2: begin
                    nxt.flags.a2 = 1'b1;
                    nxt.flags.b  = 1'b0;
                end
                PK_ALT12: begin
                    nxt.flags.a1 = 1'b1;
                    nxt.flags.a2 = 1'b1;
                    nxt.flags.b  = 1'b0;
                end
                default: nxt = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PFX_IDLE;
        else     st <= nxt;
    end

endmodule

// File: rtl/pfx_regbank.sv
module pfx_regbank
    import pfx_select_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              copy_we,
    input  logic [IDX_W-1:0]  copy_idx,
    input  logic              dp_we,
    input  logic [IDX_W-1:0]  dp_idx,
    input  logic [DATA_W-1:0] dp_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        always_ff @(posedge clk) begin
            if (rst)                                regs[i] <= '0;
            else if (copy_we && copy_idx == MY_IDX) regs[i] <= rd_data;
            else if (dp_we && !copy_we && dp_idx == MY_IDX)
                                                    regs[i] <= dp_data;
        end
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/pfx_select_unit.sv
module pfx_select_unit
    import pfx_select_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic              clear_flags,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              b_flag,
    output logic              alt1,
    output logic              alt2,
    output logic [3:0]        src_sel,
    output logic [3:0]        dst_sel,
    output logic [DATA_W-1:0] src_data,
    output logic              pc_step,
    output logic              rom_req
);

    pfx_dec_t         dec;
    pfx_state_t       st;
    logic             do_copy;
    logic [IDX_W-1:0] copy_idx;

    pfx_decoder u_dec (
        .op_valid    (op_valid),
        .opcode      (opcode),
        .clear_flags (clear_flags),
        .bind_now    (st.flags.b),
        .dec         (dec),
        .do_copy     (do_copy),
        .copy_idx    (copy_idx),
        .pc_step     (pc_step),
        .rom_req     (rom_req)
    );

    pfx_state u_state (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .clear_flags (clear_flags),
        .dec         (dec),
        .st          (st)
    );

    pfx_regbank #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .copy_we  (do_copy),
        .copy_idx (copy_idx),
        .dp_we    (wr_en),
        .dp_idx   (st.dst),
        .dp_data  (wr_data),
        .rd_idx   (st.src),
        .rd_data  (src_data)
    );

    assign b_flag  = st.flags.b;
    assign alt1    = st.flags.a1;
    assign alt2    = st.flags.a2;
    assign src_sel = st.src;
    assign dst_sel = st.dst;

endmodule

// File: rtl/pfx_select_unit_chk.sv
module pfx_select_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [7:0]        opcode,
    input logic              clear_flags,
    input logic              b_flag,
    input logic              alt1,
    input logic              alt2,
    input logic [3:0]        src_sel,
    input logic [3:0]        dst_sel,
    input logic [DATA_W-1:0] src_data,
    input logic              pc_step,
    input logic              rom_req
);

    logic is_pfx;
    assign is_pfx = (opcode[7:4] == 4'h1) || (opcode[7:4] == 4'h2) ||
                    (opcode == 8'h3D) || (opcode == 8'h3E) || (opcode == 8'h3F);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !b_flag && !alt1 && !alt2 && src_sel == 4'd0 && src_data == '0);

    // R2
    bind_sel_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !clear_flags && opcode[7:4] == 4'h2
        |=> b_flag && src_sel == $past(opcode[3:0]) && dst_sel == $past(opcode[3:0]));

    // R4
    copy_clears_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !clear_flags && b_flag && opcode[7:4] == 4'h1
        |=> !b_flag && !alt1 && !alt2 && src_sel == 4'd0 && dst_sel == 4'd0);

    // R5
    alt_both_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !clear_flags && opcode == 8'h3F |=> alt1 && alt2 && !b_flag);

    // R6
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clear_flags |=> !b_flag && !alt1 && !alt2 && src_sel == 4'd0 && dst_sel == 4'd0);

    // R6
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clear_flags |-> !pc_step && !rom_req);

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && b_flag && opcode == 8'h1F |-> !pc_step);

    // R8
    rom_only_copy_chk: assert property (@(posedge clk) disable iff (rst)
        rom_req |-> op_valid && !clear_flags && b_flag && opcode == 8'h1E);

    // R10
    other_stable_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !clear_flags && !is_pfx
        |=> $stable(b_flag) && $stable(alt1) && $stable(alt2) && $stable(src_sel) && $stable(dst_sel));

endmodule

bind pfx_select_unit pfx_select_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .clear_flags (clear_flags),
    .b_flag      (b_flag),
    .alt1        (alt1),
    .alt2        (alt2),
    .src_sel     (src_sel),
    .dst_sel     (dst_sel),
    .src_data    (src_data),
    .pc_step     (pc_step),
    .rom_req     (rom_req)
);

// File: tb/pfx_select_unit_tb.sv
module pfx_select_unit_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          op_valid, clear_flags, wr_en;
    logic [7:0]    opcode;
    logic [DW-1:0] wr_data;
    logic          b_flag, alt1, alt2, pc_step, rom_req;
    logic [3:0]    src_sel, dst_sel;
    logic [DW-1:0] src_data;

    int vectors = 0;
    int fails   = 0;

    logic [DW-1:0] m_reg [16];
    logic          m_b, m_a1, m_a2;
    logic [3:0]    m_src, m_dst;

    always #2.5 clk = ~clk;

    pfx_select_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .clear_flags(clear_flags), .wr_en(wr_en), .wr_data(wr_data),
        .b_flag(b_flag), .alt1(alt1), .alt2(alt2), .src_sel(src_sel),
        .dst_sel(dst_sel), .src_data(src_data), .pc_step(pc_step), .rom_req(rom_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(b_flag == m_b, req, "b_flag", 32'(b_flag), 32'(m_b));
        chk(alt1 == m_a1, req, "alt1", 32'(alt1), 32'(m_a1));
        chk(alt2 == m_a2, req, "alt2", 32'(alt2), 32'(m_a2));
        chk(src_sel == m_src, req, "src_sel", 32'(src_sel), 32'(m_src));
        chk(dst_sel == m_dst, req, "dst_sel", 32'(dst_sel), 32'(m_dst));
        chk(src_data == m_reg[m_src], req, "src_data", 32'(src_data), 32'(m_reg[m_src]));
    endtask

    // One cycle: drive at the falling edge, check strobes, clock, check state.
    task automatic apply(input bit v, input logic [7:0] o, input bit c,
                         input bit w, input logic [DW-1:0] wd, input string req);
        bit is_to, is_with, is_alt, acc, copy, exp_pc, exp_rom;
        @(negedge clk);
        op_valid = v; opcode = o; clear_flags = c; wr_en = w; wr_data = wd;
        is_to   = (o[7:4] == 4'h1);
        is_with = (o[7:4] == 4'h2);
        is_alt  = (o == 8'h3D) || (o == 8'h3E) || (o == 8'h3F);
        acc     = v && !c && (is_to || is_with || is_alt);
        copy    = acc && is_to && m_b;
        exp_pc  = acc && !(copy && o[3:0] == 4'hF);   // R7
        exp_rom = copy && o[3:0] == 4'hE;              // R8
        #1;
        chk(pc_step == exp_pc, "R7", "pc_step", 32'(pc_step), 32'(exp_pc));
        chk(rom_req == exp_rom, "R8", "rom_req", 32'(rom_req), 32'(exp_rom));
        @(posedge clk);
        if (copy)   m_reg[o[3:0]] = m_reg[m_src];      // R4, R9 copy wins
        else if (w) m_reg[m_dst] = wd;                 // R9
        if (c) begin
            m_b = 0; m_a1 = 0; m_a2 = 0; m_src = 0; m_dst = 0;   // R6
        end else if (acc) begin
            if (is_to) begin
                if (m_b) begin m_b = 0; m_a1 = 0; m_a2 = 0; m_src = 0; m_dst = 0; end
                else m_dst = o[3:0];                   // R3
            end else if (is_with) begin
                m_b = 1; m_src = o[3:0]; m_dst = o[3:0];           // R2
            end else begin
                m_b = 0;                                // R5
                if (o[0]) m_a1 = 1;
                if (o[1]) m_a2 = 1;
            end
        end
        #1;
        op_valid = 0; clear_flags = 0; wr_en = 0;
        chk_state(req);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1; op_valid = 0; opcode = 0; clear_flags = 0; wr_en = 0; wr_data = 0;
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_b = 0; m_a1 = 0; m_a2 = 0; m_src = 0; m_dst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: idle state, every register zero
        chk_state("R1");
        for (int i = 0; i < 16; i++) begin
            apply(1, 8'h20 | 8'(i), 0, 0, '0, "R1");
        end
        apply(0, 8'h00, 1, 0, '0, "R6");

        // Load distinct values: bind i then datapath write (R2, R9)
        for (int i = 0; i < 16; i++) begin
            apply(1, 8'h20 | 8'(i), 0, 0, '0, "R2");
            apply(0, 8'h00, 0, 1, DW'(16'hA000 + i * 16'h0111), "R9");
        end

        // Copy sweep over every source/target pair (R4)
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 16; d++) begin
                apply(1, 8'h20 | 8'(s), 0, 0, '0, "R2");
                apply(1, 8'h10 | 8'(d), 0, 0, '0, "R4");
                apply(1, 8'h20 | 8'(d), 0, 0, '0, "R4");
                apply(0, 8'h00, 0, 1, DW'(s * 16'h0F01 + d), "R9");
            end
        end

        // Full opcode sweep with bind set and clear (R3, R5, R7, R8, R10)
        for (int o = 0; o < 256; o++) begin
            for (int bset = 0; bset < 2; bset++) begin
                apply(0, 8'h00, 1, 0, '0, "R6");
                apply(1, 8'h20 | 8'(o % 16), 0, 0, '0, "R2");
                if (bset == 0) apply(1, (o % 2) ? 8'h3E : 8'h3D, 0, 0, '0, "R5");
                apply(1, 8'(o), 0, 0, '0, "R10");
                apply(1, 8'h3D, 0, 0, '0, "R5");
                apply(1, 8'h3E, 0, 0, '0, "R5");
                apply(1, 8'h10 | 8'((o + 3) % 16), 0, 0, '0, "R3");
            end
        end

        // Copy collides with datapath write (R9)
        apply(1, 8'h23, 0, 0, '0, "R2");
        apply(1, 8'h17, 0, 1, 16'hBEEF, "R9");
        apply(1, 8'h23, 0, 0, '0, "R9");
        apply(1, 8'h27, 0, 0, '0, "R9");
        // Opcode collides with clear; write still lands (R6, R9)
        apply(1, 8'h24, 0, 0, '0, "R2");
        apply(1, 8'h19, 1, 1, 16'h1234, "R6");
        apply(1, 8'h24, 0, 0, '0, "R6");
        apply(1, 8'h3F, 1, 0, '0, "R6");
        apply(1, 8'h3F, 0, 0, '0, "R5");
        // Copies into 14 and 15 (R7, R8)
        apply(1, 8'h22, 0, 0, '0, "R2");
        apply(1, 8'h1E, 0, 0, '0, "R8");
        apply(1, 8'h22, 0, 0, '0, "R2");
        apply(1, 8'h1F, 0, 0, '0, "R7");
        apply(1, 8'h1F, 0, 0, '0, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule